// File: doc/BRIEF.md
# BPSK Subcarrier Phase Demodulator

This block turns a stream of signed I/Q correlator samples from the card-to-reader channel into framed bytes. Each sample pair arrives with a one-cycle enable. While the block is unsynchronised it watches a cheap amplitude estimate. When that estimate shows a subcarrier, the block adds up a short run of samples to learn a reference phase. After that, each sample is projected onto the reference quadrant and reduced to a soft bit: a positive projection is a one, and zero or below is a zero.

Once trained, the block waits for the start-of-frame low phase and checks its length. It then groups sample pairs into bits and bits into 10-bit characters. Each data character comes out as a byte pulse. An all-zero character closes the frame with a one-cycle done pulse and the byte count. Any timing violation, malformed character or buffer overrun drops the block back to the unsynchronised state without a done pulse. Correlation, sampling and CRC checking are handled elsewhere.

Top module: `bpsk_frame_demod`

## Requirements
- R1: A synchronous reset forces `byte_valid`, `frame_done` and `frame_len` to 0. It also clears the state, position counter, reference sums, bit accumulator, bit count and character shift register, so a frame cut by reset is never completed and the next full frame decodes.
- R2: Amplitude is estimated as max(|I|,|Q|) + min(|I|>>1, |Q|>>1). Synchronisation starts only when this estimate is strictly above 8. Samples of (6,4) (estimate 8) never start it, and samples of (8,2) (estimate 9) do.
- R3: The detecting sample loads the I and Q sums. The next 7 samples are added, but only if each one still shows the subcarrier. The 9th sample only ends training. The decision value is (+I or -I) + (+Q or -Q), where the sign is + when the matching sum is above zero. A value of zero or less is logic 0. Frames decode with the subcarrier phase in any quadrant.
- R4: After training, up to 50 consecutive logic-1 samples are tolerated before the start-of-frame. The 51st returns the block to the unsynchronised state.
- R5: Count the start-of-frame low run L, including its first logic-0 sample. The low run is accepted when 20 <= L <= 27. A rise at L <= 19, or a 28th low sample, abandons synchronisation.
- R6: A bit lasts 2 samples, and its value is the sign of the sum of their decision values. A character is 10 bits, sent first to last: a 0 start bit, data bits 0 to 7 (LSB first), and a 1 stop bit. A valid character gives a one-cycle `byte_valid` with `byte_data` on the cycle after the sample that completes its stop bit. `byte_valid` and `frame_done` are never high together.
- R7: A character of ten 0 bits ends the frame. If at least one byte was received, `frame_done` pulses for one cycle with `frame_len` equal to the byte count. With no bytes there is no pulse.
- R8: A character that is neither valid nor all-zero abandons the frame. Bytes already delivered stay delivered, and no `frame_done` follows.
- R9: At most 8 bytes (MAX_BYTES) are accepted per frame. An 8-byte frame completes with `frame_len` = 8. A 9th data character is not emitted and abandons the frame.
- R10: Cycles with `smp_en` low do not advance the block, whatever their sample values. No output pulse follows such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Sample pair valid this cycle |
| smp_i | input | 8 | Signed in-phase correlator sample |
| smp_q | input | 8 | Signed quadrature correlator sample |
| byte_valid | output | 1 | One-cycle pulse: `byte_data` holds a received byte |
| byte_data | output | 8 | Received data byte |
| frame_done | output | 1 | One-cycle pulse at a valid end of frame |
| frame_len | output | 4 | Number of bytes in the completed frame |

## Verification
The main decode path is tried with reference phases in all four quadrants, and with several byte values whose bit patterns differ. This shows that the quadrant-sign projection, not one fixed axis, drives the decisions.

The amplitude gate is probed with a pair on each side of the threshold. The start-of-frame and pre-start windows are each probed at their last accepted and first rejected counts.

Malformed characters, an empty frame, and frames of eight and nine bytes separate the end-of-frame, error and overrun paths. A frame carried with idle enable-low cycles full of noise shows that only enabled samples count.

// File: rtl/bpsk_demod_pkg.sv
package bpsk_demod_pkg;

    localparam int CHAR_BITS = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TRAIN,
        ST_WAIT_SOF,
        ST_SOF_LOW,
        ST_WAIT_START,
        ST_DATA
    } dmd_state_e;

    typedef enum logic [1:0] {
        CH_DATA,
        CH_EOF,
        CH_BAD
    } char_kind_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // bit 0 is the first bit on air (start), bit 9 the last (stop)
    function automatic char_kind_e classify(input logic [CHAR_BITS-1:0] c);
        if (c == '0)
            return CH_EOF;
        else if (!c[0] && c[CHAR_BITS-1])
            return CH_DATA;
        else
            return CH_BAD;
    endfunction

endpackage

// File: rtl/bpsk_metric.sv
module bpsk_metric #(
    parameter int SMP_W  = 8,
    parameter int ACC_W  = 12,
    parameter int PROJ_W = 10,
    parameter int THRESH = 8
) (
    input  logic signed [SMP_W-1:0]  s_i,
    input  logic signed [SMP_W-1:0]  s_q,
    input  logic signed [ACC_W-1:0]  r_i,
    input  logic signed [ACC_W-1:0]  r_q,
    output logic                     present,
    output logic signed [PROJ_W-1:0] proj
);
    localparam int MAG_W = SMP_W + 1;
    localparam int AMP_W = SMP_W + 2;

    logic signed [MAG_W-1:0] x_i, x_q;
    logic        [MAG_W-1:0] m_i, m_q, big, small_half;
    logic        [AMP_W-1:0] amp;
    logic signed [PROJ_W-1:0] e_i, e_q, t_i, t_q;
    logic ri_pos, rq_pos;

    always_comb begin
        x_i = MAG_W'(s_i);
        x_q = MAG_W'(s_q);
        m_i = x_i[MAG_W-1] ? MAG_W'(-x_i) : MAG_W'(x_i);
        m_q = x_q[MAG_W-1] ? MAG_W'(-x_q) : MAG_W'(x_q);
        big        = (m_i > m_q) ? m_i : m_q;
        small_half = ((m_i >> 1) < (m_q >> 1)) ? (m_i >> 1) : (m_q >> 1);
        amp     = AMP_W'(big) + AMP_W'(small_half);
        present = amp > AMP_W'(THRESH);
    end

    always_comb begin
        ri_pos = !r_i[ACC_W-1] && (r_i != '0);
        rq_pos = !r_q[ACC_W-1] && (r_q != '0);
        e_i  = PROJ_W'(s_i);
        e_q  = PROJ_W'(s_q);
        t_i  = ri_pos ? e_i : -e_i;
        t_q  = rq_pos ? e_q : -e_q;
        proj = t_i + t_q;
    end
endmodule

// File: rtl/bpsk_phase_ref.sv
module bpsk_phase_ref #(
    parameter int SMP_W = 8,
    parameter int ACC_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic                    add,
    input  logic signed [SMP_W-1:0] s_i,
    input  logic signed [SMP_W-1:0] s_q,
    output logic signed [ACC_W-1:0] r_i,
    output logic signed [ACC_W-1:0] r_q
);
    logic signed [ACC_W-1:0] w_i, w_q;

    assign w_i = ACC_W'(s_i);
    assign w_q = ACC_W'(s_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            r_i <= '0;
            r_q <= '0;
        end else if (load) begin
            r_i <= w_i;
            r_q <= w_q;
        end else if (add) begin
            r_i <= r_i + w_i;
            r_q <= r_q + w_q;
        end
    end
endmodule

// File: rtl/bpsk_frame_fsm.sv
module bpsk_frame_fsm
    import bpsk_demod_pkg::*;
#(
    parameter int PROJ_W    = 10,
    parameter int TRAIN_N   = 8,
    parameter int WAIT_MAX  = 50,
    parameter int SOF_MIN   = 20,
    parameter int SOF_MAX   = 26,
    parameter int GAP_MAX   = 25,
    parameter int SPB       = 2,
    parameter int MAX_BYTES = 8,
    parameter int LEN_W     = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic                     present,
    input  logic signed [PROJ_W-1:0] proj,
    output logic                     ref_load,
    output logic                     ref_add,
    output logic                     byte_valid,
    output logic [7:0]               byte_data,
    output logic                     frame_done,
    output logic [LEN_W-1:0]         frame_len
);
    localparam int POS_LIM = imax(imax(WAIT_MAX, GAP_MAX), imax(imax(SOF_MAX + 1, TRAIN_N), SPB));
    localparam int POS_W   = $clog2(POS_LIM + 1);
    localparam int BACC_W  = PROJ_W + $clog2(SPB) + 1;
    localparam int NB_W    = $clog2(CHAR_BITS);

    dmd_state_e              state;
    logic [POS_W-1:0]        pos, pos_n;
    logic signed [BACC_W-1:0] bit_acc, acc_n;
    logic [CHAR_BITS-2:0]    sh;
    logic [NB_W-1:0]         nbits;
    logic [LEN_W-1:0]        len;
    logic                    is_one, bit_v;
    logic [CHAR_BITS-1:0]    chr;

    always_comb begin
        is_one = !proj[PROJ_W-1] && (proj != '0);
        pos_n  = pos + POS_W'(1);
        acc_n  = bit_acc + BACC_W'(proj);
        bit_v  = !acc_n[BACC_W-1] && (acc_n != '0);
        chr    = {bit_v, sh};
        ref_load = en && (state == ST_IDLE) && present;
        ref_add  = en && (state == ST_TRAIN) && (pos < POS_W'(TRAIN_N)) && present;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            pos        <= '0;
            bit_acc    <= '0;
            sh         <= '0;
            nbits      <= '0;
            len        <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
            frame_done <= 1'b0;
            frame_len  <= '0;
        end else begin
            byte_valid <= 1'b0;
            frame_done <= 1'b0;
            if (en) begin
                case (state)
                    ST_IDLE: begin
                        if (present) begin
                            state <= ST_TRAIN;
                            pos   <= POS_W'(1);
                            len   <= '0;
                        end
                    end
                    ST_TRAIN: begin
                        if (pos < POS_W'(TRAIN_N)) begin
                            pos <= pos_n;
                        end else begin
                            state <= ST_WAIT_SOF;
                            pos   <= '0;
                        end
                    end
                    ST_WAIT_SOF: begin
                        if (!is_one) begin
                            state <= ST_SOF_LOW;
                            pos   <= '0;
                        end else if (pos >= POS_W'(WAIT_MAX)) begin
                            state <= ST_IDLE;
                        end else begin
                            pos <= pos_n;
                        end
                    end
                    ST_SOF_LOW: begin
                        if (is_one) begin
                            if (pos_n < POS_W'(SOF_MIN)) begin
                                state <= ST_IDLE;
                            end else begin
                                state <= ST_WAIT_START;
                                pos   <= '0;
                            end
                        end else if (pos_n > POS_W'(SOF_MAX)) begin
                            state <= ST_IDLE;
                        end else begin
                            pos <= pos_n;
                        end
                    end
                    ST_WAIT_START: begin
                        if (!is_one) begin
                            state   <= ST_DATA;
                            pos     <= POS_W'(1);
                            bit_acc <= BACC_W'(proj);
                            nbits   <= '0;
                            sh      <= '0;
                        end else if (pos >= POS_W'(GAP_MAX)) begin
                            state <= ST_IDLE;
                        end else begin
                            pos <= pos_n;
                        end
                    end
                    ST_DATA: begin
                        if (pos == POS_W'(SPB - 1)) begin
                            pos     <= '0;
                            bit_acc <= '0;
                            if (nbits == NB_W'(CHAR_BITS - 1)) begin
                                case (classify(chr))
                                    CH_DATA: begin
                                        if (len == LEN_W'(MAX_BYTES)) begin
                                            state <= ST_IDLE;
                                        end else begin
                                            byte_valid <= 1'b1;
                                            byte_data  <= chr[8:1];
                                            len        <= len + LEN_W'(1);
                                            state      <= ST_WAIT_START;
                                        end
                                    end
                                    CH_EOF: begin
                                        state <= ST_IDLE;
                                        if (len != '0) begin
                                            frame_done <= 1'b1;
                                            frame_len  <= len;
                                        end
                                    end
                                    default: state <= ST_IDLE;
                                endcase
                            end else begin
                                sh    <= {bit_v, sh[CHAR_BITS-2:1]};
                                nbits <= nbits + NB_W'(1);
                            end
                        end else begin
                            pos     <= pos_n;
                            bit_acc <= acc_n;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/bpsk_frame_demod.sv
module bpsk_frame_demod #(
    parameter int SMP_W     = 8,
    parameter int THRESH    = 8,
    parameter int TRAIN_N   = 8,
    parameter int WAIT_MAX  = 50,
    parameter int SOF_MIN   = 20,
    parameter int SOF_MAX   = 26,
    parameter int GAP_MAX   = 25,
    parameter int SPB       = 2,
    parameter int MAX_BYTES = 8,
    parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_en,
    input  logic signed [SMP_W-1:0] smp_i,
    input  logic signed [SMP_W-1:0] smp_q,
    output logic                    byte_valid,
    output logic [7:0]              byte_data,
    output logic                    frame_done,
    output logic [LEN_W-1:0]        frame_len
);
    localparam int ACC_W  = SMP_W + $clog2(TRAIN_N) + 1;
    localparam int PROJ_W = SMP_W + 2;

    logic                     present, ref_load, ref_add;
    logic signed [ACC_W-1:0]  r_i, r_q;
    logic signed [PROJ_W-1:0] proj;

    bpsk_metric #(
        .SMP_W(SMP_W), .ACC_W(ACC_W), .PROJ_W(PROJ_W), .THRESH(THRESH)
    ) u_metric (
        .s_i(smp_i), .s_q(smp_q), .r_i(r_i), .r_q(r_q),
        .present(present), .proj(proj)
    );

    bpsk_phase_ref #(
        .SMP_W(SMP_W), .ACC_W(ACC_W)
    ) u_ref (
        .clk(clk), .rst(rst), .load(ref_load), .add(ref_add),
        .s_i(smp_i), .s_q(smp_q), .r_i(r_i), .r_q(r_q)
    );

    bpsk_frame_fsm #(
        .PROJ_W(PROJ_W), .TRAIN_N(TRAIN_N), .WAIT_MAX(WAIT_MAX),
        .SOF_MIN(SOF_MIN), .SOF_MAX(SOF_MAX), .GAP_MAX(GAP_MAX),
        .SPB(SPB), .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)
    ) u_fsm (
        .clk(clk), .rst(rst), .en(smp_en), .present(present), .proj(proj),
        .ref_load(ref_load), .ref_add(ref_add),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .frame_done(frame_done), .frame_len(frame_len)
    );
endmodule

// File: rtl/bpsk_frame_demod_chk.sv
module bpsk_frame_demod_chk #(
    parameter int MAX_BYTES = 8,
    parameter int LEN_W     = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_en,
    input logic             byte_valid,
    input logic             frame_done,
    input logic [LEN_W-1:0] frame_len
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!byte_valid && !frame_done && frame_len == '0));

    // R6
    byte_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);

    // R6
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(byte_valid && frame_done));

    // R7
    frame_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R7
    frame_len_nz_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (frame_len != '0));

    // R9
    frame_len_cap_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (frame_len <= LEN_W'(MAX_BYTES)));

    // R10
    stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> (!byte_valid && !frame_done));
endmodule

bind bpsk_frame_demod bpsk_frame_demod_chk #(
    .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)
) u_chk (
    .clk(clk), .rst(rst), .smp_en(smp_en), .byte_valid(byte_valid),
    .frame_done(frame_done), .frame_len(frame_len)
);

// File: tb/sim_bpsk_frame_demod.sv
module sim_bpsk_frame_demod;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_en = 1'b0;
    logic signed [7:0] smp_i = '0;
    logic signed [7:0] smp_q = '0;
    logic       byte_valid, frame_done;
    logic [7:0] byte_data;
    logic [3:0] frame_len;

    bpsk_frame_demod u0 (
        .clk(clk), .rst(rst), .smp_en(smp_en), .smp_i(smp_i), .smp_q(smp_q),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .frame_done(frame_done), .frame_len(frame_len)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    logic [7:0] rx [0:31];
    logic [7:0] tx [0:15];
    int rx_n = 0, fd_n = 0, fd_len = 0;
    logic signed [7:0] one_i = 8'sd40, one_q = 8'sd30;
    bit gap_on = 1'b0;

    // log outputs between edges
    always @(negedge clk) begin
        if (!rst) begin
            if (byte_valid) begin
                if (rx_n < 32) rx[rx_n] = byte_data;
                rx_n++;
            end
            if (frame_done) begin
                fd_n++;
                fd_len = int'(frame_len);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic smp(input logic signed [7:0] i, input logic signed [7:0] q);
        if (gap_on) begin
            @(negedge clk);
            smp_en = 1'b0; smp_i = -8'sd99; smp_q = 8'sd77;
        end
        @(negedge clk);
        smp_en = 1'b1; smp_i = i; smp_q = q;
    endtask

    task automatic quiet(input int n);
        for (int k = 0; k < n; k++) smp(8'sd0, 8'sd0);
    endtask

    task automatic one_s();  smp(one_i, one_q);   endtask
    task automatic zero_s(); smp(-one_i, -one_q); endtask

    task automatic put_bit(input bit b);
        for (int k = 0; k < 2; k++) if (b) one_s(); else zero_s();
    endtask

    task automatic put_char(input logic [7:0] d, input bit stop);
        put_bit(1'b0);
        for (int k = 0; k < 8; k++) put_bit(d[k]);
        put_bit(stop);
    endtask

    task automatic put_head(input int idle, input int sof);
        for (int k = 0; k < 9 + idle; k++) one_s();
        for (int k = 0; k < sof; k++) zero_s();
        for (int k = 0; k < 4; k++) one_s();
    endtask

    task automatic put_eof();
        for (int k = 0; k < 10; k++) put_bit(1'b0);
        quiet(2);
    endtask

    task automatic put_frame(input int n, input int idle, input int sof);
        put_head(idle, sof);
        for (int k = 0; k < n; k++) put_char(tx[k], 1'b1);
        put_eof();
    endtask

    task automatic flush();
        quiet(40);
        rx_n = 0; fd_n = 0; fd_len = 0;
    endtask

    function automatic bit intact(input int n);
        bit ok;
        ok = (fd_n == 1) && (fd_len == n) && (rx_n == n);
        for (int k = 0; k < n; k++) if (ok && rx[k] != tx[k]) ok = 1'b0;
        return ok;
    endfunction

    task automatic check_bytes(input string tag, input int n);
        chk({tag, " byte count"}, rx_n, n);
        for (int k = 0; k < n; k++) chk({tag, " byte value"}, int'(rx[k]), int'(tx[k]));
    endtask

    // R1
    task automatic t_reset();
        chk("R1 byte_valid in reset", int'(byte_valid), 0);
        chk("R1 frame_done in reset", int'(frame_done), 0);
        chk("R1 frame_len in reset", int'(frame_len), 0);
        tx[0] = 8'h77;
        put_head(3, 22);
        put_char(tx[0], 1'b1);
        put_bit(1'b1);
        @(negedge clk);
        rst = 1'b1; smp_en = 1'b0;
        @(negedge clk);
        chk("R1 byte_valid after mid-frame reset", int'(byte_valid), 0);
        chk("R1 frame_len after mid-frame reset", int'(frame_len), 0);
        rst = 1'b0;
        rx_n = 0; fd_n = 0;
        quiet(5);
        tx[0] = 8'h5A; tx[1] = 8'hC3;
        put_frame(2, 3, 22);
        chk("R1 frame after reset intact", int'(intact(2)), 1);
        flush();
    endtask

    // R6 R7
    task automatic t_basic();
        tx[0] = 8'hA5; tx[1] = 8'h3C; tx[2] = 8'h81;
        put_frame(3, 3, 22);
        check_bytes("R6 basic", 3);
        chk("R7 basic done count", fd_n, 1);
        chk("R7 basic frame_len", fd_len, 3);
        flush();
    endtask

    // R3
    task automatic t_quadrants();
        logic signed [7:0] pi [0:2];
        logic signed [7:0] pq [0:2];
        pi[0] = -8'sd30; pq[0] = 8'sd50;
        pi[1] = -8'sd45; pq[1] = -8'sd20;
        pi[2] = 8'sd25;  pq[2] = -8'sd60;
        for (int k = 0; k < 3; k++) begin
            one_i = pi[k]; one_q = pq[k];
            tx[0] = 8'h0F ^ 8'(k); tx[1] = 8'hE1;
            put_frame(2, 5, 23);
            chk("R3 quadrant frame intact", int'(intact(2)), 1);
            flush();
        end
        one_i = 8'sd40; one_q = 8'sd30;
    endtask

    // R2
    task automatic t_threshold();
        tx[0] = 8'h3E; tx[1] = 8'h01;
        one_i = 8'sd6; one_q = 8'sd4;
        put_frame(2, 3, 22);
        chk("R2 amplitude 8 bytes", rx_n, 0);
        chk("R2 amplitude 8 done", fd_n, 0);
        flush();
        one_i = 8'sd8; one_q = 8'sd2;
        put_frame(2, 3, 22);
        chk("R2 amplitude 9 frame intact", int'(intact(2)), 1);
        flush();
        one_i = 8'sd40; one_q = 8'sd30;
    endtask

    // R4
    task automatic t_idle();
        tx[0] = 8'h96; tx[1] = 8'h69;
        put_frame(2, 50, 22);
        chk("R4 50 idle samples frame intact", int'(intact(2)), 1);
        flush();
        put_frame(2, 51, 22);
        chk("R4 51 idle samples frame lost", int'(intact(2)), 0);
        flush();
    endtask

    // R5
    task automatic t_sof();
        int lens [0:3];
        int want [0:3];
        lens[0] = 19; want[0] = 0;
        lens[1] = 20; want[1] = 1;
        lens[2] = 27; want[2] = 1;
        lens[3] = 28; want[3] = 0;
        tx[0] = 8'h55; tx[1] = 8'hAA;
        for (int k = 0; k < 4; k++) begin
            put_frame(2, 4, lens[k]);
            chk($sformatf("R5 sof low %0d accepted", lens[k]), int'(intact(2)), want[k]);
            flush();
        end
    endtask

    // R7 empty frame
    task automatic t_empty();
        put_head(3, 22);
        put_eof();
        chk("R7 empty frame no done", fd_n, 0);
        chk("R7 empty frame no bytes", rx_n, 0);
        flush();
    endtask

    // R8
    task automatic t_badchar();
        tx[0] = 8'h11;
        put_head(3, 22);
        put_char(tx[0], 1'b1);
        put_char(8'h40, 1'b0);
        quiet(2);
        check_bytes("R8 bytes before bad char", 1);
        chk("R8 bad char no done", fd_n, 0);
        flush();
    endtask

    // R9
    task automatic t_overflow();
        for (int k = 0; k < 9; k++) tx[k] = 8'h20 + 8'(k * 3);
        put_frame(8, 3, 22);
        chk("R9 eight-byte frame intact", int'(intact(8)), 1);
        chk("R9 eight-byte frame_len", fd_len, 8);
        flush();
        put_frame(9, 3, 22);
        check_bytes("R9 nine-byte frame", 8);
        chk("R9 nine-byte frame no done", fd_n, 0);
        flush();
    endtask

    // R10
    task automatic t_gaps();
        tx[0] = 8'hC6; tx[1] = 8'h7B; tx[2] = 8'h00;
        gap_on = 1'b1;
        put_frame(3, 3, 22);
        gap_on = 1'b0;
        chk("R10 frame with stalled cycles intact", int'(intact(3)), 1);
        flush();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_quadrants();
        t_threshold();
        t_idle();
        t_sof();
        t_empty();
        t_badchar();
        t_overflow();
        t_gaps();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule